// File: doc/BRIEF.md
# Grouped Interrupt Level Aggregator

This block gathers thirteen device interrupt lines into one 32-bit pending word, gates that word with a 32-bit enable word, and encodes the result as a 3-bit processor priority level. Every source owns one fixed bit in the pending word, and the bits are not contiguous. Each source also belongs to one of three priority groups, at levels 3, 5 and 6. The processor side sees only the level. Software finds the cause by reading the pending word and acknowledges it by rewriting that word.

Each device line is followed by edges. A rising line sets its pending bit and a falling line clears it. Software may overwrite the pending word at any time, and a steady line does not put its bit back. When a line edge and a software write land in the same clock, the edge decides that one bit. Both words are reached over a simple word-wide register bus with a write strobe and a combinational read port.

Top module: `irq_level_agg`

## Requirements
- R1: The seven level-3 device lines map to these pending bits: dev_irq[0] floppy to bit 7, dev_irq[1] keyboard/mouse to bit 3, dev_irq[2] power to bit 2, dev_irq[3] Ethernet receive to bit 9, dev_irq[4] Ethernet transmit to bit 10, dev_irq[5] SCSI to bit 12, and dev_irq[6] clock to bit 5.
- R2: The serial controller has two lines. ser_irq[0] drives pending bit 17, which is the only level-5 source. ser_irq[1] drives serial DMA bit 21, which is in the level-6 group.
- R3: The remaining level-6 lines map as follows: dev_irq[7] Ethernet transmit DMA to bit 28, dev_irq[8] Ethernet receive DMA to bit 27, dev_irq[9] SCSI DMA to bit 26, and dev_irq[10] sound to bit 23.
- R4: A rising edge on a line sets its pending bit in the next cycle, and a falling edge clears it. While a line stays at the same level it does not change its bit, so a software clear of a bit whose line is still high sticks.
- R5: A write with bus_wr high replaces the pending word when bus_addr is 0x7000 and replaces the enable word when bus_addr is 0x7800. Reads at these offsets return the words. Any other offset reads 0, and a write to it changes neither word.
- R6: A pending bit counts toward the level only when the enable bit at the same position is 1. Pending bits that belong to no group never count.
- R7: cpu_level is 6 if any enabled pending level-6 bit is set. Otherwise it is 5 if bit 17 is enabled and pending, otherwise 3 if any enabled pending level-3 bit is set, and otherwise 0.
- R8: When a line edge and a pending-word write occur in the same cycle, the edge sets or clears that line's bit. All other bits take the written value.
- R9: Reset clears both words, and cpu_level reads 0 while no enabled bit is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_irq | input | 11 | Device interrupt lines, index order as in R1 and R3 |
| ser_irq | input | 2 | Serial controller lines: 0 = receive/transmit, 1 = DMA |
| bus_wr | input | 1 | Write strobe for one full word |
| bus_addr | input | ADDR_W (16) | Register offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| cpu_level | output | 3 | Encoded processor priority level: 0, 3, 5 or 6 |

## Verification
The bench builds the block with its default parameters: 32-bit data and a 16-bit offset, with the pending and enable words at 0x7000 and 0x7800. This puts every one of the thirteen fixed bit positions and all three group masks in reach. Each line is swept on its own to show where its bit lands and which level it raises. A table of pending and enable pairs exercises the priority order and the enable gating, including bits that belong to no group. Directed cases cover an edge and a write in the same cycle, a sticky software clear, an unused offset, and a reset in the middle of a run.

// File: rtl/irq_level_agg.sv
module irq_level_agg #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] STAT_OFS = 16'h7000,
  parameter logic [ADDR_W-1:0] MASK_OFS = 16'h7800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [10:0]       dev_irq,
  input  logic [1:0]        ser_irq,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [2:0]        cpu_level
);
  localparam int NSRC = 13;
  localparam int BITPOS [NSRC] = '{7, 3, 2, 9, 10, 12, 5, 28, 27, 26, 23, 17, 21};
  localparam int GROUP  [NSRC] = '{3, 3, 3, 3, 3, 3, 3, 6, 6, 6, 6, 5, 6};

  function automatic logic [DATA_W-1:0] group_bits(input int g);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NSRC; i++)
      if (GROUP[i] == g) m[BITPOS[i]] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] G3 = group_bits(3);
  localparam logic [DATA_W-1:0] G5 = group_bits(5);
  localparam logic [DATA_W-1:0] G6 = group_bits(6);

  logic [NSRC-1:0]   lines, lines_q, rise, fall;
  logic [DATA_W-1:0] status_q, mask_q, status_d, pend;
  logic              wr_stat, wr_mask;

  assign lines   = {ser_irq, dev_irq};
  assign rise    = lines & ~lines_q;
  assign fall    = ~lines & lines_q;
  assign wr_stat = bus_wr && (bus_addr == STAT_OFS);
  assign wr_mask = bus_wr && (bus_addr == MASK_OFS);

  always_comb begin
    status_d = wr_stat ? bus_wdata : status_q;
    for (int i = 0; i < NSRC; i++) begin
      if (rise[i])      status_d[BITPOS[i]] = 1'b1;
      else if (fall[i]) status_d[BITPOS[i]] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      lines_q  <= '0;
    end else begin
      status_q <= status_d;
      lines_q  <= lines;
      if (wr_mask) mask_q <= bus_wdata;
    end
  end

  assign pend      = status_q & mask_q;
  assign cpu_level = |(pend & G6) ? 3'd6 :
                     |(pend & G5) ? 3'd5 :
                     |(pend & G3) ? 3'd3 : 3'd0;

  assign bus_rdata = (bus_addr == STAT_OFS) ? status_q :
                     (bus_addr == MASK_OFS) ? mask_q : '0;
endmodule

// File: rtl/irq_level_agg_chk.sv
module irq_level_agg_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] MASK_OFS = 16'h7800
) (
  input logic              clk,
  input logic              rst_n,
  input logic [10:0]       dev_irq,
  input logic [1:0]        ser_irq,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] status,
  input logic [DATA_W-1:0] mask,
  input logic [2:0]        cpu_level
);
  assert_floppy_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_irq[0]) |=> status[7]);

  assert_serial_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_irq[0]) |=> !status[17]);

  assert_scsi_dma_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_irq[9]) |=> status[26]);

  assert_sound_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_irq[10]) |=> !status[23]);

  assert_mask_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == MASK_OFS) |=> mask == $past(bus_wdata));

  assert_gated_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & mask) == '0) |-> cpu_level == 3'd0);

  assert_top_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status & mask & 32'h1CA0_0000)) |-> cpu_level == 3'd6);

  assert_reset_zero_R9: assert property (@(posedge clk)
    !rst_n |=> (status == '0 && mask == '0));
endmodule

bind irq_level_agg irq_level_agg_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MASK_OFS(MASK_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .ser_irq(ser_irq),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .status(status_q), .mask(mask_q), .cpu_level(cpu_level)
);

// File: tb/test_irq_level_agg.sv
module test_irq_level_agg;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [10:0] dev_irq = '0;
  logic [1:0]  ser_irq = '0;
  logic        bus_wr = 0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  cpu_level;

  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [15:0] ST = 16'h7000, MK = 16'h7800;
  localparam int POS [13] = '{7, 3, 2, 9, 10, 12, 5, 28, 27, 26, 23, 17, 21};
  localparam int LVL [13] = '{3, 3, 3, 3, 3, 3, 3, 6, 6, 6, 6, 5, 6};
  // {pending, enable, expected level}
  localparam logic [66:0] VEC [8] = '{
    {32'h0000_0080, 32'hFFFF_FFFF, 3'd3},
    {32'h0002_0000, 32'hFFFF_FFFF, 3'd5},
    {32'h1000_0000, 32'hFFFF_FFFF, 3'd6},
    {32'h1002_0080, 32'h0000_0080, 3'd3},
    {32'h1002_0080, 32'h0002_0080, 3'd5},
    {32'hFFFF_FFFF, 32'h0000_0000, 3'd0},
    {32'h0000_0001, 32'hFFFF_FFFF, 3'd0},
    {32'h00A0_0004, 32'h0080_0004, 3'd6}
  };

  irq_level_agg i_irq_level_agg (
    .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .ser_irq(ser_irq),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_level(cpu_level)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; #1;
    check(bus_rdata === exp, tag, bus_rdata, exp);
  endtask

  task automatic lvl_chk(input logic [2:0] exp, input string tag);
    check(cpu_level === exp, tag, {29'd0, cpu_level}, {29'd0, exp});
  endtask

  task automatic set_line(input int i, input logic v);
    if (i < 11) dev_irq[i] = v; else ser_irq[i-11] = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd_chk(ST, 32'h0, "R9 pending after reset");
    rd_chk(MK, 32'h0, "R9 enable after reset");
    lvl_chk(3'd0, "R9 level after reset");

    for (int v = 0; v < 8; v++) begin
      wr(ST, VEC[v][66:35]);
      wr(MK, VEC[v][34:3]);
      rd_chk(ST, VEC[v][66:35], "R5 pending readback");
      rd_chk(MK, VEC[v][34:3], "R5 enable readback");
      lvl_chk(VEC[v][2:0], "R6/R7 table level");
    end

    wr(ST, 32'h0);
    wr(MK, 32'hFFFF_FFFF);
    for (int i = 0; i < 13; i++) begin
      @(negedge clk); set_line(i, 1'b1);
      @(negedge clk);
      rd_chk(ST, 32'h1 << POS[i], i < 7 ? "R1 line sets bit" : (i >= 11 ? "R2 serial sets bit" : "R3 line sets bit"));
      lvl_chk(LVL[i][2:0], "R7 group level per line");
      set_line(i, 1'b0);
      @(negedge clk);
      rd_chk(ST, 32'h0, "R4 falling edge clears");
      lvl_chk(3'd0, "R4 level drops after clear");
    end

    @(negedge clk);
    dev_irq[5] = 1; bus_wr = 1; bus_addr = ST; bus_wdata = 32'h0000_0001;
    @(negedge clk); bus_wr = 0;
    rd_chk(ST, 32'h0000_1001, "R8 rise beats write");
    dev_irq[5] = 0; bus_wr = 1; bus_addr = ST; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk); bus_wr = 0;
    rd_chk(ST, 32'hFFFF_EFFF, "R8 fall beats write");

    wr(ST, 32'h0);
    @(negedge clk); ser_irq[1] = 1;
    @(negedge clk);
    rd_chk(ST, 32'h0020_0000, "R2 serial DMA bit");
    wr(ST, 32'h0);
    @(negedge clk);
    rd_chk(ST, 32'h0, "R4 steady line does not re-set");
    lvl_chk(3'd0, "R4 level stays clear");
    ser_irq[1] = 0;

    wr(16'h7004, 32'h1234_5678);
    rd_chk(16'h7004, 32'h0, "R5 unused offset reads zero");
    rd_chk(ST, 32'h0, "R5 unused write leaves pending");
    rd_chk(MK, 32'hFFFF_FFFF, "R5 unused write leaves enable");

    wr(ST, 32'h0000_1000);
    wr(MK, 32'hFFFF_EFFF);
    lvl_chk(3'd0, "R6 masked bit gives no level");

    wr(ST, 32'h1002_1000);
    wr(MK, 32'hFFFF_FFFF);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd_chk(ST, 32'h0, "R9 reset clears pending");
    rd_chk(MK, 32'h0, "R9 reset clears enable");
    lvl_chk(3'd0, "R9 level after mid-run reset");

    finish_run();
  end
endmodule